// File: doc/BRIEF.md
# Polyphase Synthesis Window Buffer

This block is the last stage of a subband synthesis filter bank. For each frame it takes 32 transformed subband values from an upstream transform. It expands them into 64 matrixed values using sign and mirror symmetry, and stores those 64 values in a 1024-entry circular history held in block RAM. It then produces 32 PCM samples. Each PCM sample is a windowed sum of 16 history samples, weighted by coefficients from a separately loaded 512-entry window RAM.

Values arrive one per cycle on a valid/ready input. The window is written through a simple address/data port, normally before the first frame. PCM results leave as single-cycle pulses on a valid/data output, in slot order. All arithmetic is signed fixed point:

- samples are 16 bits;
- coefficients are 16 bits with 15 fractional bits;
- the accumulator has guard bits;
- results are saturated to 16-bit PCM.

Top module: `synth_window_buffer`

## Requirements
- R1: While reset is asserted, `in_ready` and `out_valid` are 0. Within four clock cycles of reset release, `in_ready` is 1 and no output pulse has been produced.
- R2: A sample is taken only in a cycle where `in_valid` and `in_ready` are both 1. After the 32nd sample of a frame, `in_ready` is 0 in the next cycle. It stays 0 until the frame's computation has been issued, and `in_valid` pulses in that window have no effect on any output.
- R3: The captured values u[0..31] expand to v[0..63] as follows, for k = 0..15:
  - v[k] = u[k]
  - v[31-k] = -u[k]
  - v[32+k] = u[16+k]
  - v[63-k] = -u[16+k]
- R4: When the value -32768 is negated in that expansion, the result is 32767.
- R5: Each frame first lowers the history base by 64, modulo 1024 (the base is 0 after reset, so the first frame uses 960). It then writes v[n] at history address base+n, modulo 1024.
- R6: Output slot j (0..31) is computed from the history h and the window w as the sum over taps i = 0..15 of h[(base + 128*floor(i/2) + 96*(i mod 2) + j) mod 1024] * w[32*i + j].
- R7: A history entry that has not been written since reset contributes zero.
- R8: A pulse on `coef_we` stores `coef_data` as window coefficient w[`coef_addr`]. The coefficient index is 32*i + j for tap i and slot j.
- R9: Each PCM result is the exact sum shifted right arithmetically by 15 bits and clipped to the range [-32768, 32767].
- R10: Each frame produces exactly 32 results, with `out_valid` high for one cycle per result and never in two consecutive cycles. Results appear in slot order j = 0..31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Subband value present |
| in_data | input | 16 | Signed subband value |
| in_ready | output | 1 | Block is capturing a frame |
| coef_we | input | 1 | Window coefficient write strobe |
| coef_addr | input | 9 | Window coefficient index (32*tap + slot) |
| coef_data | input | 16 | Signed Q1.15 window coefficient |
| out_valid | output | 1 | PCM result pulse |
| out_data | output | 16 | Signed saturated PCM result |

## Verification
The hardest situation to reach from the ports is a history that has wrapped around the circular buffer: more than 16 frames must be pushed before any of the oldest entries is overwritten. The bench walks a table of frame patterns for twenty frames, which fills the history from a cleared state and then wraps it. Busy-time junk is offered on the input while the buffer is not ready. Saturation needs a history full of same-signed taps. To get there, a constant full-scale window is loaded and then sixteen constant full-scale frames are pushed. Slot 0 must then clip high and slot 16 clip low.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // Sequencer phases of one frame
  typedef enum logic [1:0] {
    ST_CAP = 2'd0,   // collecting subband values
    ST_WR  = 2'd1,   // writing expanded values into history
    ST_MAC = 2'd2    // issuing window multiply-accumulate reads
  } swb_state_e;
endpackage

// File: rtl/swb_dpram.sv
module swb_dpram #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/swb_expand.sv
module swb_expand #(
  parameter int DW = 16,
  parameter int NS = 32,
  localparam int VW = $clog2(2*NS),
  localparam int SW = $clog2(NS)
) (
  input  logic [NS*DW-1:0] cap_flat,
  input  logic [VW-1:0]    idx,
  output logic [DW-1:0]    val
);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  logic          upper;
  logic [SW-1:0] pos;
  logic          mirror;
  logic [SW-1:0] sel;
  logic [DW-1:0] raw;

  always_comb begin
    upper  = idx[VW-1];
    pos    = idx[SW-1:0];
    mirror = pos[SW-1];
    // mirrored positions walk back toward the start of the half
    sel    = {upper, (mirror ? ~pos[SW-2:0] : pos[SW-2:0])};
    raw    = cap_flat[sel*DW +: DW];
    if (!mirror)         val = raw;
    else if (raw == SMIN) val = SMAX;
    else                 val = DW'(-raw);
  end
endmodule

// File: rtl/swb_mac.sv
module swb_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int GUARD = 4,
  parameter int FRAC  = 15,
  localparam int PW   = DW + CW,
  localparam int ACCW = PW + GUARD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_zero,
  input  logic [DW-1:0] hist,
  input  logic [CW-1:0] coef,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] base, ext, sum, scaled, acc_q, acc_d;
  logic                   fits;
  logic [OW-1:0]          clip, out_data_d;
  logic                   out_valid_d;

  always_comb begin
    if (in_zero) prod = '0;
    else         prod = $signed(hist) * $signed(coef);
    base   = in_first ? '0 : acc_q;
    ext    = {{GUARD{prod[PW-1]}}, prod};
    sum    = base + ext;
    scaled = sum >>> FRAC;
    fits   = (scaled[ACCW-1:OW-1] == {(ACCW-OW+1){scaled[ACCW-1]}});
    if (fits)                clip = scaled[OW-1:0];
    else if (scaled[ACCW-1]) clip = {1'b1, {(OW-1){1'b0}}};
    else                     clip = {1'b0, {(OW-1){1'b1}}};

    acc_d       = in_vld ? sum : acc_q;
    out_valid_d = in_vld && in_last;
    out_data_d  = (in_vld && in_last) ? clip : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      acc_q     <= acc_d;
      out_valid <= out_valid_d;
      out_data  <= out_data_d;
    end
  end

  // R10
  out_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_last) |=> out_valid);

  // R10
  out_only_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && in_last) |=> !out_valid);
endmodule

// File: rtl/synth_window_buffer.sv
module synth_window_buffer
  import swb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int NSUB  = 32,
  parameter int TAPS  = 16,
  parameter int GUARD = 4,
  parameter int FRAC  = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [DW-1:0]                  in_data,
  output logic                           in_ready,
  input  logic                           coef_we,
  input  logic [$clog2(NSUB*TAPS)-1:0]   coef_addr,
  input  logic [CW-1:0]                  coef_data,
  output logic                           out_valid,
  output logic [OW-1:0]                  out_data
);
  localparam int NV     = 2 * NSUB;
  localparam int HDEPTH = NV * TAPS;
  localparam int WDEPTH = NSUB * TAPS;
  localparam int HAW    = $clog2(HDEPTH);
  localparam int HAW1   = HAW + 1;
  localparam int WAW    = $clog2(WDEPTH);
  localparam int SW     = $clog2(NSUB);
  localparam int TW     = $clog2(TAPS);
  localparam int VW     = $clog2(NV);
  localparam int FW     = TW + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  swb_state_e          state_q, state_d;
  logic [SW-1:0]       cap_cnt_q, cap_cnt_d;
  logic [VW-1:0]       wr_cnt_q, wr_cnt_d;
  logic [WAW-1:0]      mac_idx_q, mac_idx_d;
  logic [HAW-1:0]      ptr_q, ptr_d;
  logic [FW-1:0]       fill_q, fill_d;
  logic [NSUB*DW-1:0]  cap_q;
  logic                cap_en, hist_we, rd_issue;

  logic [TW-1:0]       tap_i;
  logic [SW-1:0]       slot_j;
  logic [HAW-1:0]      tap_off, hist_raddr, hist_waddr;
  logic [WAW-1:0]      win_raddr;
  logic [HAW1-1:0]     fill_lim;
  logic                tap_zero;
  logic [DW-1:0]       wr_val, hist_rdata;
  logic [CW-1:0]       win_rdata;
  logic                rd_vld_q, rd_first_q, rd_last_q, rd_zero_q;

  assign in_ready = rst_q_n && (state_q == ST_CAP);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cap_cnt_d = cap_cnt_q;
    wr_cnt_d  = wr_cnt_q;
    mac_idx_d = mac_idx_q;
    ptr_d     = ptr_q;
    fill_d    = fill_q;
    cap_en    = 1'b0;
    hist_we   = 1'b0;
    rd_issue  = 1'b0;
    case (state_q)
      ST_CAP: begin
        if (in_valid && in_ready) begin
          cap_en    = 1'b1;
          cap_cnt_d = cap_cnt_q + 1'b1;
          if (cap_cnt_q == SW'(NSUB-1)) begin
            state_d = ST_WR;
            ptr_d   = ptr_q - HAW'(NV);
          end
        end
      end
      ST_WR: begin
        hist_we  = 1'b1;
        wr_cnt_d = wr_cnt_q + 1'b1;
        if (wr_cnt_q == VW'(NV-1)) begin
          state_d = ST_MAC;
          if (fill_q != FW'(TAPS)) fill_d = fill_q + 1'b1;
        end
      end
      ST_MAC: begin
        rd_issue  = 1'b1;
        mac_idx_d = mac_idx_q + 1'b1;
        if (mac_idx_q == WAW'(WDEPTH-1)) state_d = ST_CAP;
      end
      default: state_d = ST_CAP;
    endcase
  end

  // read addressing: tap index inner, output slot outer
  assign tap_i  = mac_idx_q[TW-1:0];
  assign slot_j = mac_idx_q[WAW-1:TW];

  always_comb begin
    tap_off    = HAW'(tap_i >> 1) * HAW'(2*NV)
               + (tap_i[0] ? HAW'(3*NSUB) : HAW'(0))
               + HAW'(slot_j);
    hist_raddr = ptr_q + tap_off;
    hist_waddr = ptr_q + HAW'(wr_cnt_q);
    win_raddr  = {tap_i, slot_j};
    fill_lim   = HAW1'(fill_q) * HAW1'(NV);
    tap_zero   = ({1'b0, tap_off} >= fill_lim);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q    <= ST_CAP;
      cap_cnt_q  <= '0;
      wr_cnt_q   <= '0;
      mac_idx_q  <= '0;
      ptr_q      <= '0;
      fill_q     <= '0;
      rd_vld_q   <= 1'b0;
      rd_first_q <= 1'b0;
      rd_last_q  <= 1'b0;
      rd_zero_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cap_cnt_q  <= cap_cnt_d;
      wr_cnt_q   <= wr_cnt_d;
      mac_idx_q  <= mac_idx_d;
      ptr_q      <= ptr_d;
      fill_q     <= fill_d;
      rd_vld_q   <= rd_issue;
      rd_first_q <= (tap_i == '0);
      rd_last_q  <= (tap_i == TW'(TAPS-1));
      rd_zero_q  <= tap_zero;
    end
  end

  // capture bank, clock-enabled per accepted sample
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cap_q <= '0;
    else if (cap_en) cap_q[cap_cnt_q*DW +: DW] <= in_data;
  end

  swb_expand #(.DW(DW), .NS(NSUB)) u_expand (
    .cap_flat (cap_q),
    .idx      (wr_cnt_q),
    .val      (wr_val)
  );

  swb_dpram #(.W(DW), .DEPTH(HDEPTH)) u_hist (
    .clk   (clk),
    .we    (hist_we),
    .waddr (hist_waddr),
    .wdata (wr_val),
    .re    (rd_issue),
    .raddr (hist_raddr),
    .rdata (hist_rdata)
  );

  swb_dpram #(.W(CW), .DEPTH(WDEPTH)) u_win (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_data),
    .re    (rd_issue),
    .raddr (win_raddr),
    .rdata (win_rdata)
  );

  swb_mac #(.DW(DW), .CW(CW), .OW(OW), .GUARD(GUARD), .FRAC(FRAC)) u_mac (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .in_vld    (rd_vld_q),
    .in_first  (rd_first_q),
    .in_last   (rd_last_q),
    .in_zero   (rd_zero_q),
    .hist      (hist_rdata),
    .coef      (win_rdata),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(ptr_q) |-> (ptr_q == $past(ptr_q) - HAW'(NV)));

  // R2
  cap_full_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_ready && cap_cnt_q == SW'(NSUB-1)) |=> !in_ready);

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $stable(fill_q) || (fill_q == $past(fill_q) + 1'b1 && fill_q <= FW'(TAPS)));

  // R10
  out_gap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |=> !out_valid);
endmodule

// File: tb/synth_window_buffer_tb.sv
`timescale 1ns/1ps
module synth_window_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic        coef_we;
  logic [8:0]  coef_addr;
  logic [15:0] coef_data;
  logic        out_valid;
  logic [15:0] out_data;

  always #2.5 clk = ~clk;

  synth_window_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // frame patterns: {base, step}; u[k] = base + step*k (16-bit wrap)
  localparam logic [31:0] FRAMES [6] = '{
    32'h0100_0033, 32'h8000_0000, 32'h7FFF_FC01,
    32'hF000_0101, 32'h0000_0000, 32'h1234_E5A7
  };

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  int  hist_m [1024];
  int  win_m  [512];
  int  ptr_m  = 0;
  int  got    [32];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int neg_sat(input int x);
    return (x == -32768) ? 32767 : -x;
  endfunction

  task automatic load_coefs(input int kind);
    for (int n = 0; n < 512; n++) begin
      int val;
      if (kind == 0)      val = ((n * 37 + 11) % 2001) - 1000;
      else if (kind == 1) val = 32767;
      else                val = (n == 32*3 + 5) ? 16384 : 0;
      @(negedge clk);
      coef_we = 1'b1; coef_addr = 9'(n); coef_data = 16'(val);
      win_m[n] = val;
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] pat, input bit junk, input string tag);
    int u [32];
    int v [64];
    int expv [32];
    for (int k = 0; k < 32; k++) begin
      logic [15:0] t;
      t = pat[31:16] + pat[15:0] * 16'(k);
      u[k] = int'($signed(t));
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = 16'(u[k]);
    end
    @(negedge clk);
    check(in_ready == 1'b0, {tag, " R2 busy after 32nd"}, int'(in_ready), 0);
    if (junk) begin
      in_data = 16'h5A5A;
      repeat (20) @(negedge clk);
    end
    in_valid = 1'b0;
    // model: expansion, circular write, windowed sums
    for (int n = 0; n < 64; n++) begin
      int hf, ps;
      hf = n / 32; ps = n % 32;
      if (ps < 16) v[n] = u[hf*16 + ps];
      else         v[n] = neg_sat(u[hf*16 + 31 - ps]);
    end
    ptr_m = (ptr_m - 64) & 1023;
    for (int n = 0; n < 64; n++) hist_m[(ptr_m + n) & 1023] = v[n];
    for (int j = 0; j < 32; j++) begin
      longint acc;
      acc = 0;
      for (int i = 0; i < 16; i++)
        acc += longint'(hist_m[(ptr_m + 128*(i/2) + 96*(i%2) + j) & 1023])
             * longint'(win_m[32*i + j]);
      acc = acc >>> 15;
      if (acc > 32767)       expv[j] = 32767;
      else if (acc < -32768) expv[j] = -32768;
      else                   expv[j] = int'(acc);
    end
    for (int j = 0; j < 32; j++) begin
      do @(negedge clk); while (!out_valid);
      got[j] = int'($signed(out_data));
      check(got[j] == expv[j], $sformatf("%s R6 slot %0d", tag, j), got[j], expv[j]);
    end
    @(negedge clk);
    check(in_ready == 1'b1, {tag, " R2 ready again"}, int'(in_ready), 1);
  endtask

  initial begin
    #750000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 1024; n++) hist_m[n] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after release", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 no output after release", int'(out_valid), 0);

    // R8: window loaded through the write port
    load_coefs(0);

    // table walk: first frame sees cleared history (R7), later frames wrap (R5)
    for (int f = 0; f < 20; f++) begin
      string tag;
      int e;
      e = f % 6;
      if (f == 0)          tag = "R7";
      else if (f >= 16)    tag = "R5";
      else if (e == 1)     tag = "R4";
      else if (e == 2)     tag = "R3";
      else if (f % 4 == 3) tag = "R2";
      else                 tag = "R6";
      run_frame(FRAMES[e], (f % 4 == 3), tag);
    end

    // R8: single nonzero coefficient at tap 3, slot 5
    load_coefs(2);
    run_frame(FRAMES[0], 1'b0, "R8");

    // R9: full-scale window and sixteen full-scale frames
    load_coefs(1);
    for (int f = 0; f < 16; f++) run_frame(32'h7FFF_0000, 1'b0, "R9");
    check(got[0] == 32767, "R9 clip high", got[0], 32767);
    check(got[16] == -32768, "R9 clip low", got[16], -32768);

    // R10: no extra results once a frame is done
    begin
      int extra;
      extra = 0;
      repeat (40) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      check(extra == 0, "R10 idle", extra, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule